// File: doc/BRIEF.md
# Presettable Down Counter with Zero Detect

This block is a synchronous down counter that steps one count lower on every enabled clock edge. A parallel input loads it, either at once through an asynchronous preset or at the next edge through a synchronous preset. A clear forces the count to its largest value. A parameter chooses the count encoding:

- **Binary:** the whole 8-bit range.
- **BCD:** packed decimal digits, with the tens digit in bits [7:4] and the units digit in bits [3:0].

When the count has reached zero, an active-low terminal output is pulled low, but only while counting is enabled. Several counters chain by wiring the terminal output of one stage to the count-enable input of the next. Each later stage then takes one step each time the earlier stage passes through zero.

All control inputs are active low. Priority from highest to lowest:

1. Clear.
2. Asynchronous preset.
3. Synchronous preset.
4. Clock inhibit.
5. Counting.

The asynchronous controls act on `count_o` at once through a bypass. The stored count catches up with them at the next clock edge.

Top module: `dcnt_preset`

## Requirements
- R1: During reset and after it, with every control input inactive, `count_o` equals the maximum count and `zero_n` is high. The maximum count is 255 in binary mode and 0x99 in BCD mode.
- R2: In binary mode, with `clr_n`, `apl_n` and `spl_n` high and `cen_n` low, each clock edge lowers the count by one. A count of 0 steps to 255.
- R3: In BCD mode, a step works on the digits as follows:
  - A nonzero units digit drops by one.
  - A units digit of 0 with a nonzero tens digit becomes 9, and the tens digit drops by one.
  - A count of 0x00 steps to 0x99.
- R4: In BCD mode, data holding a non-decimal nibble (for example 0x0C or 0xA0) is loaded unchanged. It then steps by the R3 rules, so 0x0C steps to 0x0B and 0xA0 steps to 0x99.
- R5: With `cen_n` high and the other controls inactive, the count holds across clock edges.
- R6: With `spl_n` low and `clr_n` and `apl_n` high, the next clock edge loads `data_in`, whatever the level of `cen_n`.
- R7: While `apl_n` is low and `clr_n` is high, `count_o` equals `data_in` without waiting for an edge. After `apl_n` is released, the loaded value stays in place, provided a clock edge occurred while `apl_n` was low. `apl_n` takes priority over `spl_n`.
- R8: While `clr_n` is low, `count_o` equals the maximum count without waiting for an edge, taking priority over both presets. The value stays in place after release, provided a clock edge occurred during the clear.
- R9: `zero_n` is low exactly when `count_o` is zero and `cen_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_n | input | 1 | Clear to maximum count, active low, acts at once |
| apl_n | input | 1 | Asynchronous preset from `data_in`, active low |
| spl_n | input | 1 | Synchronous preset from `data_in`, active low |
| cen_n | input | 1 | Count enable, active low (high inhibits counting) |
| data_in | input | 8 | Parallel preset value |
| count_o | output | 8 | Current count, including the asynchronous overrides |
| zero_n | output | 1 | Terminal count, low at zero while counting is enabled |

## Verification
- **Edge-clocked results (R2 to R6):** counting, hold and synchronous loading show on `count_o` right after the clock edge that samples the controls. There is one register between control and output, so the bench drives inputs shortly after each rising edge. It advances its behavioural model on that edge and compares at the following falling edge.
- **Asynchronous results (R7, R8, R9):** both asynchronous overrides and `zero_n` are combinational and due in the same cycle. The bench probes them once more shortly after changing the inputs, before any edge occurs.
- **Reset (R1):** the reset synchroniser adds two cycles before the register leaves reset. The bench therefore keeps every control inactive for several cycles after releasing reset, and the model's reset value stays valid throughout.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic {ENC_BIN = 1'b0, ENC_BCD = 1'b1} enc_e;
endpackage

// File: rtl/dcnt_step.sv
// One down-step of the count in the selected encoding.
module dcnt_step #(
  parameter dcnt_pkg::enc_e ENC = dcnt_pkg::ENC_BIN,
  parameter int DIGITS = 2,
  parameter int DIG_W  = 4,
  localparam int W     = DIGITS * DIG_W
) (
  input  logic [W-1:0] q_i,
  output logic [W-1:0] q_dec_o
);
  localparam logic [DIG_W-1:0] D_ONE  = {{(DIG_W-1){1'b0}}, 1'b1};
  localparam logic [DIG_W-1:0] D_NINE = DIG_W'(9);
  localparam logic [W-1:0]     W_ONE  = {{(W-1){1'b0}}, 1'b1};

  if (ENC == dcnt_pkg::ENC_BCD) begin : g_bcd
    // brw[i] means that digit i must take a borrow.
    logic [DIGITS-1:0] brw;
    assign brw[0] = 1'b1;
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [DIG_W-1:0] d;
      assign d = q_i[i*DIG_W +: DIG_W];
      assign q_dec_o[i*DIG_W +: DIG_W] =
        !brw[i] ? d : ((d == '0) ? D_NINE : d - D_ONE);
      if (i < DIGITS-1) begin : g_chain
        assign brw[i+1] = brw[i] && (d == '0);
      end
    end
  end else begin : g_bin
    assign q_dec_o = q_i - W_ONE;
  end
endmodule

// File: rtl/dcnt_next.sv
// Control priority: builds the register's next value and load enable,
// and the visible count with the asynchronous overrides applied.
module dcnt_next #(
  parameter int W = 8
) (
  input  logic         clr_n,
  input  logic         apl_n,
  input  logic         spl_n,
  input  logic         cen_n,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] max_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] q_dec_i,
  output logic [W-1:0] q_nxt_o,
  output logic         q_en_o,
  output logic [W-1:0] q_view_o
);
  always_comb begin
    q_en_o  = 1'b1;
    q_nxt_o = q_dec_i;
    if (!clr_n)                  q_nxt_o = max_i;
    else if (!apl_n || !spl_n)   q_nxt_o = data_in;
    else if (cen_n)              q_en_o  = 1'b0;
  end

  always_comb begin
    if (!clr_n)      q_view_o = max_i;
    else if (!apl_n) q_view_o = data_in;
    else             q_view_o = q_i;
  end
endmodule

// File: rtl/dcnt_preset.sv
module dcnt_preset #(
  parameter dcnt_pkg::enc_e ENC = dcnt_pkg::ENC_BIN,
  parameter int DIGITS = 2,
  parameter int DIG_W  = 4,
  localparam int W     = DIGITS * DIG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         apl_n,
  input  logic         spl_n,
  input  logic         cen_n,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] count_o,
  output logic         zero_n
);
  function automatic logic [W-1:0] max_count();
    logic [W-1:0] m;
    for (int i = 0; i < DIGITS; i++)
      m[i*DIG_W +: DIG_W] = (ENC == dcnt_pkg::ENC_BCD) ? DIG_W'(9) : '1;
    return m;
  endfunction
  localparam logic [W-1:0] MAXC  = max_count();
  localparam logic [W-1:0] W_ONE = {{(W-1){1'b0}}, 1'b1};

  // Reset synchroniser: asserts at once, releases after two edges.
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [W-1:0] q_reg, q_dec, q_nxt, q_view;
  logic         q_en;

  dcnt_step #(.ENC(ENC), .DIGITS(DIGITS), .DIG_W(DIG_W)) u_step (
    .q_i(q_reg), .q_dec_o(q_dec)
  );

  dcnt_next #(.W(W)) u_next (
    .clr_n(clr_n), .apl_n(apl_n), .spl_n(spl_n), .cen_n(cen_n),
    .data_in(data_in), .max_i(MAXC), .q_i(q_reg), .q_dec_i(q_dec),
    .q_nxt_o(q_nxt), .q_en_o(q_en), .q_view_o(q_view)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  q_reg <= MAXC;
    else if (q_en)   q_reg <= q_nxt;
  end

  assign count_o = q_view;
  assign zero_n  = !((q_view == '0) && !cen_n);

  // Assertions
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_n && apl_n && spl_n && cen_n) |=> $stable(q_reg));

  a_r6_sync_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_n && apl_n && !spl_n) |=> (q_reg == $past(data_in)));

  a_r7_async_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_n && !apl_n) |-> (count_o == data_in));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clr_n |=> (q_reg == MAXC));

  a_r9_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !zero_n |-> ((count_o == '0) && !cen_n));

  if (ENC == dcnt_pkg::ENC_BIN) begin : g_chk_bin
    a_r2_bin_step: assert property (@(posedge clk) disable iff (!rst_int_n)
      (clr_n && apl_n && spl_n && !cen_n) |=> (q_reg == $past(q_reg) - W_ONE));
  end else begin : g_chk_bcd
    a_r3_bcd_wrap: assert property (@(posedge clk) disable iff (!rst_int_n)
      (clr_n && apl_n && spl_n && !cen_n && q_reg == '0) |=> (q_reg == MAXC));
  end
endmodule

// File: tb/dcnt_preset_tb.sv
`timescale 1ns/1ps
module dcnt_preset_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst_n, clr_n, apl_n, spl_n, cen_n;
  logic [7:0] data_in;
  logic [7:0] cnt_b, cnt_d;
  logic       zn_b, zn_d;

  dcnt_preset #(.ENC(dcnt_pkg::ENC_BIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .apl_n(apl_n), .spl_n(spl_n),
    .cen_n(cen_n), .data_in(data_in), .count_o(cnt_b), .zero_n(zn_b));

  dcnt_preset #(.ENC(dcnt_pkg::ENC_BCD)) u_dut_bcd (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .apl_n(apl_n), .spl_n(spl_n),
    .cen_n(cen_n), .data_in(data_in), .count_o(cnt_d), .zero_n(zn_d));

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";
  int    mb, md;   // model counts: binary, BCD

  function automatic int step_bin(int q); return (q + 255) % 256; endfunction
  function automatic int step_bcd(int q);
    int u = q % 16, t = q / 16;
    if (u != 0) return q - 1;
    if (t != 0) return (t - 1) * 16 + 9;
    return 'h99;
  endfunction

  function automatic int nxt(int q, int mx, bit bcd);
    if (!clr_n)               return mx;
    if (!apl_n || !spl_n)     return int'(data_in);
    if (cen_n)                return q;
    return bcd ? step_bcd(q) : step_bin(q);
  endfunction
  function automatic int view(int q, int mx);
    if (!clr_n) return mx;
    if (!apl_n) return int'(data_in);
    return q;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin mb <= 255; md <= 'h99; end
    else begin mb <= nxt(mb, 255, 1'b0); md <= nxt(md, 'h99, 1'b1); end
  end

  task automatic chk(string t, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    int vb = view(mb, 255), vd = view(md, 'h99);
    chk({tag, " bin count"}, int'(cnt_b), vb);
    chk({tag, " bcd count"}, int'(cnt_d), vd);
    chk("R9 bin zero_n", int'(zn_b), (vb == 0 && !cen_n) ? 0 : 1);
    chk("R9 bcd zero_n", int'(zn_d), (vd == 0 && !cen_n) ? 0 : 1);
  endtask

  always @(negedge clk) if (!done) cmp_all();

  task automatic drv(bit c, bit a, bit s, bit e, logic [7:0] d);
    @(posedge clk); #0.5;
    clr_n = c; apl_n = a; spl_n = s; cen_n = e; data_in = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; clr_n = 1; apl_n = 1; spl_n = 1; cen_n = 1; data_in = 8'h00;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    repeat (5) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 bin max", int'(cnt_b), 255);
    chk("R1 bcd max", int'(cnt_d), 'h99);
    chk("R1 zero_n high", int'(zn_b & zn_d), 1);

    // R2 / R3: load 3, count through zero and wrap
    tag = "R6";
    drv(1, 1, 0, 1, 8'h03);
    tag = "R2 R3";
    drv(1, 1, 1, 0, 8'h00);
    repeat (6) drv(1, 1, 1, 0, 8'h00);

    // R3: tens borrow from 0x20
    tag = "R6";
    drv(1, 1, 0, 0, 8'h20);
    tag = "R3";
    repeat (3) drv(1, 1, 1, 0, 8'h00);

    // R4: non-decimal nibbles
    tag = "R4";
    drv(1, 1, 0, 1, 8'h0C);
    repeat (2) drv(1, 1, 1, 0, 8'h00);
    drv(1, 1, 0, 1, 8'hA0);
    repeat (2) drv(1, 1, 1, 0, 8'h00);

    // R5: hold, including at zero with counting inhibited
    tag = "R5";
    drv(1, 1, 0, 1, 8'h00);
    repeat (4) drv(1, 1, 1, 1, 8'h55);

    // R7: asynchronous preset visible before any edge, beats spl_n
    tag = "R7";
    drv(1, 0, 0, 1, 8'h42);
    #0.5;
    chk("R7 bin immediate", int'(cnt_b), 'h42);
    chk("R7 bcd immediate", int'(cnt_d), 'h42);
    data_in = 8'h17; #0.5;
    chk("R7 follows data", int'(cnt_b), 'h17);
    drv(1, 1, 1, 1, 8'h00);
    drv(1, 1, 1, 0, 8'h00);

    // R8: clear beats asynchronous preset, visible before any edge
    tag = "R8";
    drv(0, 0, 0, 0, 8'h33);
    #0.5;
    chk("R8 bin immediate", int'(cnt_b), 255);
    chk("R8 bcd immediate", int'(cnt_d), 'h99);
    drv(1, 1, 1, 1, 8'h00);
    drv(1, 1, 1, 0, 8'h00);

    // R9: zero flag follows cen_n at zero
    tag = "R9";
    drv(1, 1, 0, 1, 8'h00);
    drv(1, 1, 1, 0, 8'h00);
    #0.5 cen_n = 1; #0.5;
    chk("R9 inhibited at zero", int'(zn_b), 1);

    // Mixed random traffic
    tag = "R2 R3 R6";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      drv(r < 3 ? 1'b0 : 1'b1, (r >= 3 && r < 8) ? 1'b0 : 1'b1,
          (r >= 8 && r < 16) ? 1'b0 : 1'b1, ($urandom_range(0, 9) < 3) ? 1'b1 : 1'b0,
          ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 255)));
    end
    drv(1, 1, 1, 1, 8'h00);
    @(posedge clk); #1;
    finish_run();
  end
endmodule